// File: doc/BRIEF.md
# Fractional Baud-Rate Tick Generator

This block turns a peripheral clock into the 16x-oversampling tick that a UART's transmitter and receiver both step on. The rate is set by a 16-bit integer divisor, written as two bytes, and a fractional factor Mul/(Mul+Add) held in one byte. The resulting tick rate is clock / (divisor × (Mul+Add)/Mul), so the bit rate is one sixteenth of that. Only one tick output exists, so receive sampling and transmit shifting can never drift apart in rate.

Software reaches the block through a small write port with four addresses. The two divisor bytes share their addresses with the data path of the surrounding UART. They accept writes only while the access bit of the line-control byte is set. The fraction byte is always writable. The fractional stretch comes from an accumulator. Each time the integer counter runs out, the accumulator either emits a tick and adds Add, or, when it has reached Mul, subtracts Mul and lets that integer period pass silently. Over Mul ticks this spends exactly Mul+Add integer periods.

Top module: `frac_baud_gen`

## Requirements
- R1: While rst_n is low, os_tick is 0. Reset leaves the divisor at 0, the fraction byte at 0x00 and the access bit clear, so after reset is released os_tick is high in every cycle.
- R2: With fraction scaling off, os_tick pulses every D clock cycles. D = 256 × (byte at address 1) + (byte at address 0). The first pulse is registered D cycles after the clock edge that accepted the last configuration write.
- R3: With Mul and Add both non-zero, the k-th tick (k = 1, 2, …) after a restart is registered D × (k + floor((k−1) × Add / Mul)) cycles after the restart edge. The average tick period is therefore D × (Mul+Add)/Mul.
- R4: The fraction byte at address 2 carries Mul in bits 7:4 and Add in bits 3:0.
- R5: A fraction byte with Mul = 0 or Add = 0 gives the plain integer rate of R2.
- R6: A divisor of 0 behaves exactly like a divisor of 1.
- R7: Writes to address 0 or 1 are ignored unless the access bit (bit 7 of the line-control byte at address 3) is set. An ignored write changes neither the rate nor the tick phase.
- R8: Every accepted write to address 0, 1 or 2 restarts the generator. It clears the integer counter and the accumulator, and the tick schedule of R2/R3 begins again from that edge.
- R9: The tick is 16x oversampling. With D = 1 and fraction byte 0x87, sixteen tick periods span 30 clock cycles, which is 500,000 bit/s from a 15 MHz clock. The same os_tick serves receive and transmit.
- R10: When D is 2 or more, os_tick is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 2 | Register select: 0 divisor low, 1 divisor high, 2 fraction, 3 line control |
| cfg_wdata | input | 8 | Write data |
| os_tick | output | 1 | 16x-oversampling tick shared by receiver and transmitter |

## Verification
On every cycle, assertions check several invariants:
- the integer counter stays below its effective limit and is zeroed by a restart;
- the accumulator stays below Mul+Add, and stays at zero while scaling is off;
- a tick only follows an integer expiry;
- locked divisor writes leave the divisor untouched;
- the fraction fields land where R4 places them;
- ticks are single-cycle once the divisor exceeds one.

Only the bench scenarios can show the exact tick schedule and the average rate for each Mul/Add pair. The same holds for the 30-cycle bit span of the 8/15 setting, for the phase staying intact across an ignored divisor write, and for the schedule starting afresh after a rewrite.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

    typedef enum logic [1:0] {
        REG_DIV_LO = 2'd0,
        REG_DIV_HI = 2'd1,
        REG_FRAC   = 2'd2,
        REG_LINE   = 2'd3
    } fbg_reg_e;

    localparam int FBG_ADDR_W = 2;

endpackage

// File: rtl/fbg_regs.sv
module fbg_regs
    import fbg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [FBG_ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0]     cfg_wdata,
    output logic [2*DATA_W-1:0]   div,
    output logic [DATA_W/2-1:0]   mul,
    output logic [DATA_W/2-1:0]   dadd,
    output logic                  restart
);
    localparam int DIV_W      = 2 * DATA_W;
    localparam int FRAC_W     = DATA_W / 2;
    localparam int ACCESS_BIT = DATA_W - 1;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [FRAC_W-1:0] mul;
        logic [FRAC_W-1:0] dadd;
        logic              unlocked;
    } regs_s;

    regs_s s_d, s_q;

    always_comb begin
        s_d     = s_q;
        restart = 1'b0;
        if (cfg_we) begin
            case (fbg_reg_e'(cfg_addr))
                REG_DIV_LO: begin
                    if (s_q.unlocked) begin
                        s_d.div[DATA_W-1:0] = cfg_wdata;
                        restart             = 1'b1;
                    end
                end
                REG_DIV_HI: begin
                    if (s_q.unlocked) begin
                        s_d.div[DIV_W-1:DATA_W] = cfg_wdata;
                        restart                 = 1'b1;
                    end
                end
                REG_FRAC: begin
                    s_d.mul  = cfg_wdata[DATA_W-1:FRAC_W];
                    s_d.dadd = cfg_wdata[FRAC_W-1:0];
                    restart  = 1'b1;
                end
                default: begin
                    s_d.unlocked = cfg_wdata[ACCESS_BIT];
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign div  = s_q.div;
    assign mul  = s_q.mul;
    assign dadd = s_q.dadd;

    // R7: a divisor write while locked leaves the divisor unchanged
    p_locked_div_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !s_q.unlocked && (cfg_addr == REG_DIV_LO || cfg_addr == REG_DIV_HI))
        |=> $stable(s_q.div));

    // R4: upper nibble is Mul, lower nibble is Add
    p_frac_fields_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == REG_FRAC)
        |=> (s_q.mul == $past(cfg_wdata[DATA_W-1:FRAC_W]) &&
             s_q.dadd == $past(cfg_wdata[FRAC_W-1:0])));

endmodule

// File: rtl/fbg_int_div.sv
module fbg_int_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             expire
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } cnt_s;

    cnt_s             s_d, s_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        // R6: a zero divisor counts like a divisor of one
        lim    = (div == '0) ? '0 : div - DIV_W'(1);
        expire = !restart && (s_q.cnt == lim);
        s_d    = s_q;
        if (restart || expire) s_d.cnt = '0;
        else                   s_d.cnt = s_q.cnt + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2: the counter never runs past the effective period
    p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= lim);

    // R8: a restart leaves the counter at zero
    p_restart_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (s_q.cnt == '0));

endmodule

// File: rtl/fbg_frac.sv
module fbg_frac #(
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              expire,
    input  logic [FRAC_W-1:0] mul,
    input  logic [FRAC_W-1:0] dadd,
    output logic              tick
);
    localparam int ACC_W = FRAC_W + 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             tick;
    } frac_s;

    frac_s            s_d, s_q;
    logic [ACC_W-1:0] mul_x, dadd_x;
    logic             scale_on;

    always_comb begin
        mul_x    = {1'b0, mul};
        dadd_x   = {1'b0, dadd};
        // R5: either field at zero turns scaling off
        scale_on = (mul != '0) && (dadd != '0);
        s_d      = s_q;
        s_d.tick = 1'b0;
        if (restart) begin
            s_d.acc = '0;
        end else if (expire) begin
            if (scale_on && s_q.acc >= mul_x) begin
                s_d.acc = s_q.acc - mul_x;
            end else begin
                s_d.tick = 1'b1;
                if (scale_on) s_d.acc = s_q.acc + dadd_x;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick = s_q.tick;

    // R3: accumulator stays below Mul+Add
    p_acc_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        scale_on |-> (s_q.acc < mul_x + dadd_x));

    // R5: no accumulation while scaling is off
    p_idle_acc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !scale_on |-> (s_q.acc == '0));

    // R3: a tick only follows an integer expiry
    p_tick_after_expiry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !expire |=> !s_q.tick);

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import fbg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [FBG_ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0]     cfg_wdata,
    output logic                  os_tick
);
    localparam int DIV_W  = 2 * DATA_W;
    localparam int FRAC_W = DATA_W / 2;

    logic [DIV_W-1:0]  div;
    logic [FRAC_W-1:0] mul, dadd;
    logic              restart, expire;

    fbg_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .div       (div),
        .mul       (mul),
        .dadd      (dadd),
        .restart   (restart)
    );

    fbg_int_div #(.DIV_W(DIV_W)) u_int_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .div     (div),
        .expire  (expire)
    );

    fbg_frac #(.FRAC_W(FRAC_W)) u_frac (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .expire  (expire),
        .mul     (mul),
        .dadd    (dadd),
        .tick    (os_tick)
    );

    // R10: single-cycle pulses once the divisor exceeds one
    p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (div > DIV_W'(1) && os_tick) |=> !os_tick);

endmodule

// File: tb/tb_frac_baud_gen.sv
`timescale 1ns/1ps
module tb_frac_baud_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = 2'd0;
    logic [7:0] cfg_wdata = 8'd0;
    logic       os_tick;

    longint cyc = 0;
    longint base = 0;
    longint first_t = 0;
    longint last_t = 0;
    int     nchk = 0;
    int     nfail = 0;
    bit     done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    frac_baud_gen dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .os_tick   (os_tick)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    endtask

    always @(negedge clk) begin
        if (cyc >= 190000 && !done) begin
            nfail++;
            $display("FAIL watchdog all requirements actual=%0d expected=%0d", cyc, 190000);
            summary();
        end
    end

    // one register write; returns at the falling edge after the accepting edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg(input logic [15:0] dv, input logic [7:0] fr);
        wr(2'd3, 8'h80);
        wr(2'd0, dv[7:0]);
        wr(2'd1, dv[15:8]);
        wr(2'd3, 8'h00);
        wr(2'd2, fr);
        base = cyc;
    endtask

    // registered cycle offset of tick k after the restart edge (R2, R3, R5)
    function automatic longint exp_off(input int d, input int m, input int a, input int k);
        longint e;
        e = k;
        if (m != 0 && a != 0) e = e + ((k - 1) * a) / m;
        return e * d;
    endfunction

    // check ticks k0..k1 of the schedule against base
    task automatic run_seq(input int d, input int m, input int a, input int k0, input int k1, input string tag);
        for (int k = k0; k <= k1; k++) begin
            int w;
            w = 0;
            @(negedge clk);
            while (os_tick !== 1'b1 && w < 6000) begin
                @(negedge clk);
                w++;
            end
            if (k == k0) first_t = cyc;
            last_t = cyc;
            check(cyc - base == exp_off(d, m, a, k), tag, cyc - base, exp_off(d, m, a, k));
        end
    endtask

    initial begin
        // R1: quiet during reset
        repeat (3) begin
            @(negedge clk);
            check(os_tick == 1'b0, "R1 tick low in reset", os_tick, 0);
        end
        rst_n = 1'b1;
        base = cyc;
        run_seq(1, 0, 0, 1, 6, "R1 default rate after reset");

        // R2: integer rates, both divisor bytes
        cfg(16'd2, 8'h00);
        run_seq(2, 0, 0, 1, 6, "R2 div 2");
        @(negedge clk);
        check(os_tick == 1'b0, "R10 pulse width div 2", os_tick, 0);
        cfg(16'd3, 8'h00);   run_seq(3, 0, 0, 1, 6, "R2 div 3");
        cfg(16'd5, 8'h00);   run_seq(5, 0, 0, 1, 6, "R2 div 5");
        cfg(16'd16, 8'h00);  run_seq(16, 0, 0, 1, 4, "R2 div 16");
        cfg(16'h0102, 8'h00); run_seq(258, 0, 0, 1, 3, "R2 div 0x0102");

        // R6: zero divisor counts as one
        cfg(16'd0, 8'h00);   run_seq(1, 0, 0, 1, 5, "R6 div 0 integer");
        cfg(16'd0, 8'h21);   run_seq(1, 2, 1, 1, 8, "R6 div 0 fractional");

        // R5: either fraction field zero
        cfg(16'd3, 8'h05);   run_seq(3, 0, 5, 1, 6, "R5 mul zero");
        cfg(16'd3, 8'h90);   run_seq(3, 9, 0, 1, 6, "R5 add zero");

        // R4: nibble order matters
        cfg(16'd2, 8'h87);   run_seq(2, 8, 7, 1, 10, "R4 mul 8 add 7");
        cfg(16'd2, 8'h78);   run_seq(2, 7, 8, 1, 10, "R4 mul 7 add 8");

        // R9: 16 ticks per bit, 8/15 at divisor 1 gives a 30-cycle bit
        cfg(16'd1, 8'h87);
        run_seq(1, 8, 7, 1, 17, "R9 schedule 0x87");
        check(last_t - first_t == 30, "R9 bit span 30 cycles", last_t - first_t, 30);

        // R7: locked divisor writes neither change rate nor restart phase
        cfg(16'd4, 8'h00);
        run_seq(4, 0, 0, 1, 3, "R7 before locked write");
        wr(2'd0, 8'd9);
        run_seq(4, 0, 0, 4, 5, "R7 after locked low write");
        wr(2'd1, 8'h01);
        run_seq(4, 0, 0, 6, 7, "R7 after locked high write");

        // R8: rewrite restarts counter and accumulator
        cfg(16'd2, 8'h87);
        run_seq(2, 8, 7, 1, 5, "R8 before rewrite");
        wr(2'd2, 8'h87);
        base = cyc;
        run_seq(2, 8, 7, 1, 10, "R8 after fraction rewrite");
        wr(2'd3, 8'h80);
        wr(2'd0, 8'd3);
        base = cyc;
        run_seq(3, 8, 7, 1, 8, "R8 after divisor rewrite");
        wr(2'd3, 8'h00);

        // R3: sweep every Mul/Add pair at two divisors
        for (int d = 1; d <= 3; d += 2) begin
            cfg(16'(d), 8'h00);
            for (int m = 1; m < 16; m++) begin
                for (int a = 0; a < 16; a++) begin
                    wr(2'd2, {4'(m), 4'(a)});
                    base = cyc;
                    run_seq(d, m, a, 1, 17, "R3 fractional schedule");
                end
            end
        end

        summary();
    end

endmodule